// File: doc/BRIEF.md
# Clock-Ratio Bus Access Sequencer

This block sits in the fast CPU clock domain and turns single CPU read and write requests into timed accesses on two slower buses. One is an external memory bus stepped by a system-clock enable. The other is an internal peripheral bus stepped by a peripheral-clock enable. Both enables are derived inside the block from the fast clock. A frequency-mode pin and a 2-bit ratio field select how many fast cycles make up one slow period. The ratio decoder restarts the phase counters whenever the selection changes.

A request is accepted only when the sequencer is idle. Its latency is then fixed at the acceptance edge. First come alignment waits up to the next slow-clock enable: the system enable for synchronous external accesses, the peripheral enable for internal peripheral accesses, and none for asynchronous external accesses. A fixed overhead follows, plus the external bus cycle count for external accesses. The block then pulses `done` for one cycle.

With the store buffer enabled, a write is acknowledged in the cycle after acceptance. It keeps the bus busy while it drains and pulses `drain_done` when the drain ends. Any later request stalls until the drain has finished, so accesses reach the bus in program order.

Top module: `bus_seq`

## Requirements
- R1: With `mode_hi`=1, `ratio` 2'b10 makes `sys_ce` high once every 4 cycles, 2'b01 once every 2 cycles, and 2'b00 every cycle. In all three cases `io_ce` is high once every 4 cycles.
- R2: With `mode_hi`=0, both `sys_ce` and `io_ce` are high in every cycle, whatever the value of `ratio`.
- R3: When `mode_hi`=1 and `ratio`=2'b11 are sampled in an idle cycle, `ratio_err` is 1 in the next cycle and the previous clock selection stays in force. A legal selection sampled while idle clears `ratio_err`.
- R4: The selection is sampled only in idle cycles (`bus_act`=0). When a sampled selection differs from the current one, both phase counters restart: `sys_ce` and `io_ce` are then high in the next cycle and follow the new period from there.
- R5: An external access (`ext_sel`=1) with `ext_sync`=1 accepted at the edge ending cycle t has latency L = W + C + `bus_cycles`, where C is 3 for a read (`wr`=0) and 2 for a write (`wr`=1). W is the number of cycles from t to the first cycle at or after t with `sys_ce` high (0 if `sys_ce` is high in t). `done` is high in cycle t+L.
- R6: An external access with `ext_sync`=0 has W = 0 in the R5 formula.
- R7: An internal peripheral access (`ext_sel`=0) has latency L = V + 7 for a read and V + 6 for a write. V is counted as W in R5 but against `io_ce`. `bus_cycles` is ignored.
- R8: A request (`req`=1) is accepted only while `bus_act`=0 and `done`=0. `done` lasts exactly one cycle. From acceptance until completion, `bus_act`=1 and `bus_addr`, `bus_we`, `bus_ext` and `bus_wdata` hold the accepted request.
- R9: A write accepted with `sb_en`=1 gives `done` in cycle t+1. `bus_act` stays 1 until the latency of R5 to R7 has elapsed, and `drain_done` is then high for one cycle in cycle t+L instead of `done`.
- R10: A read or write requested while a posted write drains is not accepted before the drain ends. Its `done` comes after `drain_done`, and its latency is counted from its own acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast CPU clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_hi | input | 1 | Frequency-mode pin; 1 = ratio field selects the multiplier |
| ratio | input | 2 | Multiplier code: 00 x1, 01 x2, 10 x4, 11 illegal |
| ext_sync | input | 1 | 1 = external bus synchronous, 0 = asynchronous |
| sb_en | input | 1 | Store buffer enable |
| bus_cycles | input | BCW | External bus cycle count, sampled at acceptance |
| req | input | 1 | Access request, held until `done` |
| wr | input | 1 | 1 = write, 0 = read |
| ext_sel | input | 1 | 1 = external memory, 0 = internal peripheral bus |
| addr | input | AW | Access address |
| wdata | input | DW | Write data |
| done | output | 1 | One-cycle completion or posted acknowledge |
| ratio_err | output | 1 | Illegal selection seen while idle |
| sys_ce | output | 1 | System-clock enable |
| io_ce | output | 1 | Peripheral-clock enable |
| drain_done | output | 1 | One-cycle pulse when a posted write finishes |
| bus_act | output | 1 | Access or drain in progress |
| bus_we | output | 1 | Write flag of the access in progress |
| bus_ext | output | 1 | Target of the access in progress |
| bus_addr | output | AW | Address of the access in progress |
| bus_wdata | output | DW | Data of the access in progress |

## Verification
The bench uses the default parameters: a 2-bit phase counter, which covers divisors of 1, 2 and 4 and every alignment wait from 0 to 3, and a 4-bit bus cycle count, so the longest external access of 3 + 3 + 15 cycles is reachable. Idle gaps of 0 to 3 cycles before each access walk the request across every phase of both slow enables. The bench also moves the selection mid-access, drives the illegal code, and queues reads and writes behind a draining posted write.

// File: rtl/bseq_pkg.sv
`timescale 1ns/1ps
package bseq_pkg;
  typedef enum logic [1:0] {
    RT_X1  = 2'b00,
    RT_X2  = 2'b01,
    RT_X4  = 2'b10,
    RT_BAD = 2'b11
  } ratio_e;

  localparam int EXT_RD_OVH = 3;
  localparam int EXT_WR_OVH = 2;
  localparam int IO_RD_CYC  = 7;
  localparam int IO_WR_CYC  = 6;
  localparam int IO_SHIFT   = 2;  // peripheral clock is a quarter of the CPU clock
endpackage

// File: rtl/bseq_ratio_dec.sv
`timescale 1ns/1ps
module bseq_ratio_dec
  import bseq_pkg::*;
#(
  parameter int SHW = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           upd,
  input  logic           mode_hi,
  input  logic [1:0]     ratio,
  output logic [SHW-1:0] sys_sh,
  output logic [SHW-1:0] io_sh,
  output logic           restart,
  output logic           ratio_err
);
  logic           illegal;
  logic [SHW-1:0] nxt_sys;
  logic [SHW-1:0] nxt_io;

  always_comb begin
    illegal = mode_hi && (ratio == RT_BAD);
    nxt_sys = '0;
    nxt_io  = '0;
    if (mode_hi) begin
      nxt_io = SHW'(IO_SHIFT);
      case (ratio)
        RT_X4:   nxt_sys = SHW'(2);
        RT_X2:   nxt_sys = SHW'(1);
        default: nxt_sys = '0;
      endcase
    end
  end

  assign restart = upd && !illegal && ((nxt_sys != sys_sh) || (nxt_io != io_sh));

  always_ff @(posedge clk) begin
    if (rst) begin
      sys_sh    <= '0;
      io_sh     <= '0;
      ratio_err <= 1'b0;
    end else if (upd) begin
      ratio_err <= illegal;
      if (!illegal) begin
        sys_sh <= nxt_sys;
        io_sh  <= nxt_io;
      end
    end
  end
endmodule

// File: rtl/bseq_phase.sv
`timescale 1ns/1ps
module bseq_phase #(
  parameter int PW  = 2,
  parameter int SHW = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           restart,
  input  logic [SHW-1:0] sh,
  output logic           ce,
  output logic [PW-1:0]  wait_cnt
);
  logic [PW-1:0] ph;
  logic [PW-1:0] mask;

  assign mask     = ~({PW{1'b1}} << sh);
  assign ce       = (ph == '0);
  assign wait_cnt = (~ph + 1'b1) & mask;

  always_ff @(posedge clk) begin
    if (rst || restart) ph <= '0;
    else                ph <= (ph + 1'b1) & mask;
  end
endmodule

// File: rtl/bseq_engine.sv
`timescale 1ns/1ps
module bseq_engine
  import bseq_pkg::*;
#(
  parameter int AW  = 16,
  parameter int DW  = 32,
  parameter int BCW = 4,
  parameter int PW  = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           req,
  input  logic           wr,
  input  logic           ext_sel,
  input  logic           ext_sync,
  input  logic           sb_en,
  input  logic [BCW-1:0] bus_cycles,
  input  logic [AW-1:0]  addr,
  input  logic [DW-1:0]  wdata,
  input  logic [PW-1:0]  sys_wait,
  input  logic [PW-1:0]  io_wait,
  output logic           busy,
  output logic           done,
  output logic           drain_done,
  output logic           bus_we,
  output logic           bus_ext,
  output logic [AW-1:0]  bus_addr,
  output logic [DW-1:0]  bus_wdata
);
  localparam int LW = BCW + PW + 2;

  logic [LW-1:0] lat;
  logic [LW-1:0] left;
  logic          posted;
  logic          accept;
  logic [LW-1:0] align;
  logic [LW-1:0] ovh;

  assign accept = !busy && req && !done;

  always_comb begin
    if (ext_sel) begin
      align = ext_sync ? LW'(sys_wait) : '0;
      ovh   = wr ? LW'(EXT_WR_OVH) : LW'(EXT_RD_OVH);
      lat   = align + ovh + LW'(bus_cycles);
    end else begin
      align = LW'(io_wait);
      ovh   = wr ? LW'(IO_WR_CYC) : LW'(IO_RD_CYC);
      lat   = align + ovh;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      left       <= '0;
      posted     <= 1'b0;
      done       <= 1'b0;
      drain_done <= 1'b0;
      bus_we     <= 1'b0;
      bus_ext    <= 1'b0;
      bus_addr   <= '0;
      bus_wdata  <= '0;
    end else begin
      done       <= 1'b0;
      drain_done <= 1'b0;
      if (accept) begin
        busy      <= 1'b1;
        left      <= lat - 1'b1;
        posted    <= wr && sb_en;
        done      <= wr && sb_en;
        bus_we    <= wr;
        bus_ext   <= ext_sel;
        bus_addr  <= addr;
        bus_wdata <= wdata;
      end else if (busy) begin
        if (left == LW'(1)) begin
          busy <= 1'b0;
          if (posted) drain_done <= 1'b1;
          else        done       <= 1'b1;
        end else begin
          left <= left - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/bus_seq.sv
`timescale 1ns/1ps
module bus_seq #(
  parameter int AW  = 16,
  parameter int DW  = 32,
  parameter int BCW = 4,
  parameter int PW  = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           mode_hi,
  input  logic [1:0]     ratio,
  input  logic           ext_sync,
  input  logic           sb_en,
  input  logic [BCW-1:0] bus_cycles,
  input  logic           req,
  input  logic           wr,
  input  logic           ext_sel,
  input  logic [AW-1:0]  addr,
  input  logic [DW-1:0]  wdata,
  output logic           done,
  output logic           ratio_err,
  output logic           sys_ce,
  output logic           io_ce,
  output logic           drain_done,
  output logic           bus_act,
  output logic           bus_we,
  output logic           bus_ext,
  output logic [AW-1:0]  bus_addr,
  output logic [DW-1:0]  bus_wdata
);
  localparam int SHW  = $clog2(PW + 1);
  localparam int NDOM = 2;  // 0: system clock, 1: peripheral clock

  logic           restart;
  logic           busy;
  logic [SHW-1:0] sh_arr   [NDOM];
  logic [PW-1:0]  wait_arr [NDOM];
  logic           ce_arr   [NDOM];

  bseq_ratio_dec #(.SHW(SHW)) u_dec (
    .clk       (clk),
    .rst       (rst),
    .upd       (!busy),
    .mode_hi   (mode_hi),
    .ratio     (ratio),
    .sys_sh    (sh_arr[0]),
    .io_sh     (sh_arr[1]),
    .restart   (restart),
    .ratio_err (ratio_err)
  );

  for (genvar g = 0; g < NDOM; g++) begin : g_dom
    bseq_phase #(.PW(PW), .SHW(SHW)) u_ph (
      .clk      (clk),
      .rst      (rst),
      .restart  (restart),
      .sh       (sh_arr[g]),
      .ce       (ce_arr[g]),
      .wait_cnt (wait_arr[g])
    );
  end

  assign sys_ce  = ce_arr[0];
  assign io_ce   = ce_arr[1];
  assign bus_act = busy;

  bseq_engine #(.AW(AW), .DW(DW), .BCW(BCW), .PW(PW)) u_eng (
    .clk        (clk),
    .rst        (rst),
    .req        (req),
    .wr         (wr),
    .ext_sel    (ext_sel),
    .ext_sync   (ext_sync),
    .sb_en      (sb_en),
    .bus_cycles (bus_cycles),
    .addr       (addr),
    .wdata      (wdata),
    .sys_wait   (wait_arr[0]),
    .io_wait    (wait_arr[1]),
    .busy       (busy),
    .done       (done),
    .drain_done (drain_done),
    .bus_we     (bus_we),
    .bus_ext    (bus_ext),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata)
  );
endmodule

// File: rtl/bseq_chk.sv
`timescale 1ns/1ps
module bseq_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          mode_hi,
  input logic [1:0]    ratio,
  input logic          req,
  input logic          wr,
  input logic          sb_en,
  input logic          done,
  input logic          drain_done,
  input logic          ratio_err,
  input logic          bus_act,
  input logic [AW-1:0] bus_addr
);
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst) done |=> !done);  // R8
  AST_ILLEGAL_FLAG: assert property (@(posedge clk) disable iff (rst)
    (!bus_act && mode_hi && ratio == 2'b11) |=> ratio_err);  // R3
  AST_POSTED_ACK: assert property (@(posedge clk) disable iff (rst)
    (!bus_act && !done && req && wr && sb_en) |=> (done && bus_act));  // R9
  AST_XFER_HELD: assert property (@(posedge clk) disable iff (rst)
    bus_act |=> $stable(bus_addr));  // R8
  AST_DRAIN_APART: assert property (@(posedge clk) disable iff (rst)
    drain_done |-> !done);  // R10
endmodule

bind bus_seq bseq_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .mode_hi    (mode_hi),
  .ratio      (ratio),
  .req        (req),
  .wr         (wr),
  .sb_en      (sb_en),
  .done       (done),
  .drain_done (drain_done),
  .ratio_err  (ratio_err),
  .bus_act    (bus_act),
  .bus_addr   (bus_addr)
);

// File: tb/test_bus_seq.sv
`timescale 1ns/1ps
module test_bus_seq;
  localparam int AW = 16, DW = 32, BCW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_hi = 1'b0;
  logic [1:0] ratio = 2'b00;
  logic ext_sync = 1'b0, sb_en = 1'b0, req = 1'b0, wr = 1'b0, ext_sel = 1'b0;
  logic [BCW-1:0] bus_cycles = '0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic done, ratio_err, sys_ce, io_ce, drain_done, bus_act, bus_we, bus_ext;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;

  always #4 clk = ~clk;

  bus_seq #(.AW(AW), .DW(DW), .BCW(BCW)) i_bus_seq (
    .clk(clk), .rst(rst), .mode_hi(mode_hi), .ratio(ratio), .ext_sync(ext_sync),
    .sb_en(sb_en), .bus_cycles(bus_cycles), .req(req), .wr(wr), .ext_sel(ext_sel),
    .addr(addr), .wdata(wdata), .done(done), .ratio_err(ratio_err), .sys_ce(sys_ce),
    .io_ce(io_ce), .drain_done(drain_done), .bus_act(bus_act), .bus_we(bus_we),
    .bus_ext(bus_ext), .bus_addr(bus_addr), .bus_wdata(bus_wdata)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0, last_drain = -1;
  bit started = 0, reported = 0;

  // behavioural reference state
  int s_div = 1, i_div = 1, s_ph = 0, i_ph = 0, m_left = 0;
  bit m_busy = 0, m_post = 0, m_done = 0, m_drain = 0, m_err = 0;
  int m_addr = 0;

  task automatic chk(input string tag, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic summary();
    if (!reported) begin
      reported = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    end
  endtask

  always @(posedge clk) begin : model
    int sw, iw, lat, nd, ni;
    bit idle, chg, nbusy, ndone, ndrain, ill;
    cyc++;
    if (rst) begin
      started = 1;
      s_div = 1; i_div = 1; s_ph = 0; i_ph = 0; m_left = 0;
      m_busy = 0; m_post = 0; m_done = 0; m_drain = 0; m_err = 0; m_addr = 0;
    end else begin
      idle = !m_busy; nbusy = m_busy; ndone = 0; ndrain = 0;
      if (idle && req && !m_done) begin
        sw = (s_div - s_ph) % s_div;
        iw = (i_div - i_ph) % i_div;
        if (ext_sel) lat = (ext_sync ? sw : 0) + (wr ? 2 : 3) + int'(bus_cycles);
        else         lat = iw + (wr ? 6 : 7);
        nbusy = 1; m_left = lat - 1; m_post = wr && sb_en; ndone = m_post; m_addr = int'(addr);
      end else if (m_busy) begin
        if (m_left == 1) begin
          nbusy = 0;
          if (m_post) ndrain = 1; else ndone = 1;
        end else m_left--;
      end
      chg = 0;
      if (idle) begin
        ill = mode_hi && ratio == 2'b11;
        m_err = ill;
        if (!ill) begin
          nd = !mode_hi ? 1 : (ratio == 2'b10 ? 4 : (ratio == 2'b01 ? 2 : 1));
          ni = mode_hi ? 4 : 1;
          chg = (nd != s_div) || (ni != i_div);
          s_div = nd; i_div = ni;
        end
      end
      if (chg) begin s_ph = 0; i_ph = 0; end
      else begin s_ph = (s_ph + 1) % s_div; i_ph = (i_ph + 1) % i_div; end
      m_busy = nbusy; m_done = ndone; m_drain = ndrain;
    end
  end

  always @(negedge clk) begin
    if (started && !rst) begin
      chk("R5 R6 R7 R8 done", done, m_done);
      chk("R9 R10 drain_done", drain_done, m_drain);
      chk("R1 R2 R4 sys_ce", sys_ce, s_ph == 0);
      chk("R1 R2 R4 io_ce", io_ce, i_ph == 0);
      chk("R3 ratio_err", ratio_err, m_err);
      chk("R8 R9 bus_act", bus_act, m_busy);
      if (m_busy) chk("R8 R10 bus_addr", bus_addr, m_addr);
      if (drain_done) last_drain = cyc;
    end
  end

  task automatic idle_n(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic access(input bit e, input bit w, input bit sy, input bit sb,
                        input int bc, input int a, output int dcyc);
    @(negedge clk);
    ext_sel = e; wr = w; ext_sync = sy; sb_en = sb; bus_cycles = BCW'(bc);
    addr = AW'(a); wdata = DW'(a * 3 + 1); req = 1'b1;
    do @(negedge clk); while (!done);
    dcyc = cyc; req = 1'b0;
  endtask

  task automatic sweep(input int base);
    int d;
    for (int g = 0; g < 4; g++) begin
      idle_n(g);
      access(1, 0, 1, 0, g + 1, base + g, d);      // R5 sync read
      idle_n(g);
      access(1, 1, 1, 0, 15 - g, base + 8 + g, d); // R5 sync write
      idle_n(g);
      access(1, 0, 0, 0, g, base + 16 + g, d);     // R6 async read
      idle_n(g);
      access(0, 0, 0, 0, 9, base + 24 + g, d);     // R7 io read, count ignored
      idle_n(g);
      access(0, 1, 1, 0, 3, base + 32 + g, d);     // R7 io write
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin : stim
    int d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle_n(4);                        // reset state checked every cycle
    // R2 half-speed mode
    mode_hi = 0; ratio = 2'b10; idle_n(3);
    sweep(16'h0100);
    // R1 x4, x2, x1 selections
    mode_hi = 1; ratio = 2'b10; idle_n(5);
    sweep(16'h0200);
    ratio = 2'b01; idle_n(3);
    sweep(16'h0300);
    ratio = 2'b00; idle_n(3);
    sweep(16'h0400);
    // R3 illegal code keeps previous selection
    ratio = 2'b10; idle_n(2);
    ratio = 2'b11; idle_n(6);
    access(1, 0, 1, 0, 2, 16'h0500, d);
    idle_n(1);
    ratio = 2'b10; idle_n(3);
    // R4 selection change while busy only lands when idle
    @(negedge clk);
    ext_sel = 1; wr = 0; ext_sync = 1; sb_en = 0; bus_cycles = 4'd15; addr = 16'h0600; req = 1;
    repeat (3) @(negedge clk);
    ratio = 2'b01;
    do @(negedge clk); while (!done);
    req = 0; idle_n(4);
    // R9 posted writes, R10 ordering behind the drain
    for (int g = 0; g < 3; g++) begin
      access(1, 1, 1, 1, 6 + g, 16'h0700 + g, d);
      access(1, 0, 1, 1, 1, 16'h0700 + g, d);       // read same address
      chk("R10 read after drain", d > last_drain, 1);
      access(0, 1, 0, 1, 0, 16'h0710 + g, d);
      access(0, 1, 0, 1, 0, 16'h0720 + g, d);       // write while full
      chk("R10 write after drain", d > last_drain, 1);
      access(1, 0, 0, 1, 2, 16'h0730 + g, d);       // read other address
      chk("R10 other read after drain", d > last_drain, 1);
      idle_n(g);
    end
    mode_hi = 0; idle_n(2);
    access(0, 1, 1, 1, 0, 16'h0800, d);
    access(0, 0, 1, 0, 0, 16'h0801, d);
    idle_n(20);
    summary();
    $finish;
  end
endmodule